// File: doc/BRIEF.md
# Reset Source Status Recorder

This block keeps a record of which reset source a reset controller acknowledged most recently. The controller gives it a one-cycle pulse for each acknowledged reset, with a separate input for each source: power-on, external pin, PLL lock loss, clock loss, and watchdog or debug. When a reset ends, a release pulse makes the block sample the wake-up configuration pin and the two boot configuration pins. Software reads all of this as a single 32-bit status word through a simple register read port at offset 0x0C.

The power-on flag follows its own rule. It is set by the asynchronous power-on reset and by a power-on acknowledge. A later external-pin reset does not disturb it, but any of the other three sources clears it. The remaining four source flags are one-hot, so they show only the last source acknowledged.

Bit numbering in the status word counts from the most significant end. Status bit n is therefore word bit 31-n.

Top module: `rst_src_recorder`

## Requirements
- R1: While porRstN is low, and after it is released, the word reads 0x8000_0000: power-on flag (word bit 31) set, every other bit 0, captured pins 0.
- R2: An acknowledge of external (word bit 30), lock loss (bit 29), clock loss (bit 28) or watchdog/debug (bit 27) sets that flag and clears the other three.
- R3: An external acknowledge on its own leaves the power-on flag unchanged.
- R4: An acknowledge of lock loss, clock loss or watchdog/debug clears the power-on flag.
- R5: A power-on acknowledge sets the power-on flag and clears all four other source flags.
- R6: If several acknowledges arrive in the same cycle, one source wins, in this order: power-on, then clock loss, then lock loss, then watchdog/debug, then external.
- R7: On a rstRelease pulse, wakePin is stored at word bit 15, bootPin[1] at word bit 1 and bootPin[0] at word bit 0. These stored values do not change until the next release pulse or power-on reset.
- R8: A read of offset 0x0C returns the word with rdValid high on the cycle after rdEn. A read of any other offset returns 0 with rdValid high. Outside a read, rdValid is 0 and rdData is 0.
- R9: A write has no effect on the word, and bits not named above always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| ackPor | input | 1 | Power-on reset acknowledged pulse |
| ackExt | input | 1 | External pin reset acknowledged pulse |
| ackLol | input | 1 | PLL lock loss reset acknowledged pulse |
| ackLoc | input | 1 | Clock loss reset acknowledged pulse |
| ackWdg | input | 1 | Watchdog/debug reset acknowledged pulse |
| rstRelease | input | 1 | Reset end pulse; triggers pin capture |
| wakePin | input | 1 | Wake-up configuration pin level |
| bootPin | input | 2 | Boot configuration pin levels |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe (ignored) |
| addr | input | 8 | Byte offset of the access |
| wrData | input | 32 | Write data (ignored) |
| rdData | output | 32 | Read data, valid one cycle after rdEn |
| rdValid | output | 1 | Read data valid |

## Verification
The bench goes after the power-on flag's asymmetry in both directions. A design that cleared the flag on an external reset would lose bit 31 right after the first external pulse. A design that kept the flag on a lock-loss, clock-loss or watchdog reset would still show it afterwards.

Simultaneous acknowledges are driven in several combinations. A wrong priority order would leave the wrong one-hot flag set, and would set or clear the power-on flag wrongly.

The bench changes the pins between release pulses. A design that let the pins flow through, or sampled them on the wrong strobe, would show the new levels too early.

Reads at a wrong offset and writes of all ones expose decode errors and any write path.

// File: rtl/rstrec_pkg.sv
package rstrec_pkg;
  localparam int NUM_SRC  = 5;
  localparam int WORD_W   = 32;
  // status bit positions, counted from the most significant end
  localparam int SRC_POR  = 0;
  localparam int SRC_EXT  = 1;
  localparam int SRC_LOL  = 2;
  localparam int SRC_LOC  = 3;
  localparam int SRC_WDG  = 4;
  localparam int WAKE_POS = 16;
  localparam int BOOT_POS = 30;

  typedef struct packed {
    logic                 anyAck;
    logic                 setPor;
    logic                 clrPor;
    logic [NUM_SRC-1:1]   selOther;
    logic                 capture;
    logic                 rdStrobe;
    logic                 rdHit;
  } ctrlStrobes_t;

  function automatic int wordIdx(input int statusBit);
    return WORD_W - 1 - statusBit;
  endfunction
endpackage

// File: rtl/rstrec_ctrl.sv
module rstrec_ctrl
  import rstrec_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  STATUS_OFS = 8'h0C
) (
  input  logic                clk,
  input  logic                porRstN,
  input  logic [NUM_SRC-1:0]  ackVec,
  input  logic                rstRelease,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  output ctrlStrobes_t        strobes
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(STATUS_OFS);

  always_comb begin
    strobes          = '0;
    strobes.anyAck   = |ackVec;
    strobes.capture  = rstRelease;
    strobes.rdStrobe = rdEn;
    strobes.rdHit    = rdEn && (addr == OFS);
    // fixed priority: power-on, clock loss, lock loss, watchdog, external
    if (ackVec[SRC_POR]) begin
      strobes.setPor = 1'b1;
    end else if (ackVec[SRC_LOC]) begin
      strobes.selOther[SRC_LOC] = 1'b1;
      strobes.clrPor            = 1'b1;
    end else if (ackVec[SRC_LOL]) begin
      strobes.selOther[SRC_LOL] = 1'b1;
      strobes.clrPor            = 1'b1;
    end else if (ackVec[SRC_WDG]) begin
      strobes.selOther[SRC_WDG] = 1'b1;
      strobes.clrPor            = 1'b1;
    end else if (ackVec[SRC_EXT]) begin
      strobes.selOther[SRC_EXT] = 1'b1;
    end
  end

  // R6: a power-on acknowledge always wins over everything else
  a_r6_por_wins: assert property (@(posedge clk) disable iff (!porRstN)
    ackVec[SRC_POR] |-> (strobes.setPor && strobes.selOther == '0 && !strobes.clrPor));
  // R6: clock loss beats lock loss, watchdog and external
  a_r6_loc_beats_rest: assert property (@(posedge clk) disable iff (!porRstN)
    (ackVec[SRC_LOC] && !ackVec[SRC_POR]) |-> strobes.selOther[SRC_LOC]);
endmodule

// File: rtl/rstrec_dp.sv
module rstrec_dp
  import rstrec_pkg::*;
(
  input  logic               clk,
  input  logic               porRstN,
  input  ctrlStrobes_t       strobes,
  input  logic               wakePin,
  input  logic [1:0]         bootPin,
  input  logic               wrEn,
  input  logic [WORD_W-1:0]  wrData,
  output logic [WORD_W-1:0]  rdData,
  output logic               rdValid
);
  logic [NUM_SRC-1:0] flags;
  logic               wakeHeld;
  logic [1:0]         bootHeld;
  logic [WORD_W-1:0]  statusWord;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      flags <= NUM_SRC'(1) << SRC_POR;
    end else if (strobes.anyAck) begin
      flags[SRC_POR]       <= strobes.setPor | (flags[SRC_POR] & ~strobes.clrPor);
      flags[NUM_SRC-1:1]   <= strobes.selOther;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      wakeHeld <= 1'b0;
      bootHeld <= 2'b00;
    end else if (strobes.capture) begin
      wakeHeld <= wakePin;
      bootHeld <= bootPin;
    end
  end

  always_comb begin
    statusWord = '0;
    for (int i = 0; i < NUM_SRC; i++) statusWord[wordIdx(i)] = flags[i];
    statusWord[wordIdx(WAKE_POS)]     = wakeHeld;
    statusWord[wordIdx(BOOT_POS)]     = bootHeld[1];
    statusWord[wordIdx(BOOT_POS + 1)] = bootHeld[0];
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobes.rdStrobe;
      rdData  <= strobes.rdHit ? statusWord : '0;
    end
  end

  a_r2_onehot_sources: assert property (@(posedge clk) disable iff (!porRstN)
    $onehot0(flags[NUM_SRC-1:1]));
  a_r3_ext_keeps_por: assert property (@(posedge clk) disable iff (!porRstN)
    (strobes.anyAck && !strobes.setPor && !strobes.clrPor) |=> flags[SRC_POR] == $past(flags[SRC_POR]));
  a_r4_clear_por: assert property (@(posedge clk) disable iff (!porRstN)
    strobes.clrPor |=> !flags[SRC_POR]);
  a_r5_por_sets: assert property (@(posedge clk) disable iff (!porRstN)
    strobes.setPor |=> (flags[SRC_POR] && flags[NUM_SRC-1:1] == '0));
  a_r7_pins_held: assert property (@(posedge clk) disable iff (!porRstN)
    !strobes.capture |=> ($stable(wakeHeld) && $stable(bootHeld)));
  a_r8_read_latency: assert property (@(posedge clk) disable iff (!porRstN)
    strobes.rdStrobe |=> rdValid);
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!porRstN)
    !strobes.rdStrobe |=> (!rdValid && rdData == '0));
  a_r9_write_ignored: assert property (@(posedge clk) disable iff (!porRstN)
    (wrEn && wrData != '0 && !strobes.anyAck) |=> $stable(flags));
endmodule

// File: rtl/rst_src_recorder.sv
module rst_src_recorder
  import rstrec_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  STATUS_OFS = 8'h0C
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               ackPor,
  input  logic               ackExt,
  input  logic               ackLol,
  input  logic               ackLoc,
  input  logic               ackWdg,
  input  logic               rstRelease,
  input  logic               wakePin,
  input  logic [1:0]         bootPin,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  wrData,
  output logic [WORD_W-1:0]  rdData,
  output logic               rdValid
);
  ctrlStrobes_t       strobes;
  logic [NUM_SRC-1:0] ackVec;

  always_comb begin
    ackVec          = '0;
    ackVec[SRC_POR] = ackPor;
    ackVec[SRC_EXT] = ackExt;
    ackVec[SRC_LOL] = ackLol;
    ackVec[SRC_LOC] = ackLoc;
    ackVec[SRC_WDG] = ackWdg;
  end

  rstrec_ctrl #(.ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS)) u_ctrl (
    .clk(clk), .porRstN(porRstN), .ackVec(ackVec), .rstRelease(rstRelease),
    .rdEn(rdEn), .addr(addr), .strobes(strobes)
  );

  rstrec_dp u_dp (
    .clk(clk), .porRstN(porRstN), .strobes(strobes), .wakePin(wakePin),
    .bootPin(bootPin), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/rst_src_recorder_test.sv
`timescale 1ns/1ps
module rst_src_recorder_test;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        ackPor = 0, ackExt = 0, ackLol = 0, ackLoc = 0, ackWdg = 0;
  logic        rstRelease = 0, wakePin = 0;
  logic [1:0]  bootPin = 2'b00;
  logic        rdEn = 0, wrEn = 0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdValid;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  rst_src_recorder uut (
    .clk(clk), .porRstN(porRstN), .ackPor(ackPor), .ackExt(ackExt),
    .ackLol(ackLol), .ackLoc(ackLoc), .ackWdg(ackWdg), .rstRelease(rstRelease),
    .wakePin(wakePin), .bootPin(bootPin), .rdEn(rdEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  function automatic logic [31:0] word(bit por, bit ext, bit lol, bit loc, bit wdg,
                                       bit wake, logic [1:0] boot);
    logic [31:0] w = '0;
    w[31] = por; w[30] = ext; w[29] = lol; w[28] = loc; w[27] = wdg;
    w[15] = wake; w[1] = boot[1]; w[0] = boot[0];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readAt(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData; v = rdValid;
  endtask

  task automatic expectWord(string req, logic [31:0] exp);
    logic [31:0] d; logic v;
    readAt(8'h0C, d, v);
    check(req, d, exp);
    check({req, " valid"}, {31'b0, v}, 32'd1);
  endtask

  task automatic pulse(bit p, bit e, bit l, bit c, bit w);
    @(negedge clk);
    ackPor = p; ackExt = e; ackLol = l; ackLoc = c; ackWdg = w;
    @(negedge clk);
    ackPor = 0; ackExt = 0; ackLol = 0; ackLoc = 0; ackWdg = 0;
  endtask

  task automatic releasePins(bit wk, logic [1:0] bt);
    @(negedge clk);
    wakePin = wk; bootPin = bt; rstRelease = 1'b1;
    @(negedge clk);
    rstRelease = 1'b0;
  endtask

  task automatic testReset();
    porRstN = 1'b0;
    #1;
    check("R1 async", rdData, 32'h0);
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    expectWord("R1", word(1,0,0,0,0,0,2'b00));
  endtask

  task automatic testPorRule();
    pulse(0,1,0,0,0); expectWord("R3 ext keeps por", word(1,1,0,0,0,0,2'b00));
    pulse(0,0,1,0,0); expectWord("R4 lol clears por", word(0,0,1,0,0,0,2'b00));
    pulse(1,0,0,0,0); expectWord("R5 por ack", word(1,0,0,0,0,0,2'b00));
    pulse(0,0,0,1,0); expectWord("R4 loc clears por", word(0,0,0,1,0,0,2'b00));
    pulse(1,0,0,0,0);
    pulse(0,0,0,0,1); expectWord("R4 wdg clears por", word(0,0,0,0,1,0,2'b00));
  endtask

  task automatic testOneHot();
    pulse(0,0,0,1,0); expectWord("R2 loc", word(0,0,0,1,0,0,2'b00));
    pulse(0,0,1,0,0); expectWord("R2 lol", word(0,0,1,0,0,0,2'b00));
    pulse(0,1,0,0,0); expectWord("R2 ext", word(0,1,0,0,0,0,2'b00));
    pulse(0,0,0,0,1); expectWord("R2 wdg", word(0,0,0,0,1,0,2'b00));
  endtask

  task automatic testPriority();
    pulse(0,1,0,0,1); expectWord("R6 wdg over ext", word(0,0,0,0,1,0,2'b00));
    pulse(1,0,0,1,0); expectWord("R6 por over loc", word(1,0,0,0,0,0,2'b00));
    pulse(0,1,1,1,1); expectWord("R6 loc over rest", word(0,0,0,1,0,0,2'b00));
    pulse(0,0,1,0,1); expectWord("R6 lol over wdg", word(0,0,1,0,0,0,2'b00));
    pulse(1,1,1,1,1); expectWord("R6 por over all", word(1,0,0,0,0,0,2'b00));
    pulse(0,0,1,0,0);
  endtask

  task automatic testPins();
    releasePins(1'b1, 2'b10);
    expectWord("R7 capture", word(0,0,1,0,0,1,2'b10));
    @(negedge clk); wakePin = 1'b0; bootPin = 2'b01;
    repeat (2) @(negedge clk);
    expectWord("R7 held", word(0,0,1,0,0,1,2'b10));
    releasePins(1'b0, 2'b01);
    expectWord("R7 recapture", word(0,0,1,0,0,0,2'b01));
  endtask

  task automatic testBus();
    logic [31:0] d; logic v;
    readAt(8'h10, d, v);
    check("R8 other offset data", d, 32'h0);
    check("R8 other offset valid", {31'b0, v}, 32'd1);
    @(negedge clk);
    check("R8 idle valid", {31'b0, rdValid}, 32'd0);
    check("R8 idle data", rdData, 32'h0);
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h0C; wrData = 32'hFFFF_FFFF;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    expectWord("R9 write ignored", word(0,0,1,0,0,0,2'b01));
  endtask

  task automatic testReReset();
    pulse(0,1,0,0,0);
    @(negedge clk); porRstN = 1'b0;
    @(negedge clk); porRstN = 1'b1;
    expectWord("R1 re-reset", word(1,0,0,0,0,0,2'b00));
  endtask

  initial begin
    testReset();
    testPorRule();
    testOneHot();
    testPriority();
    testPins();
    testBus();
    testReReset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule